// File: doc/BRIEF.md
# LPC Memory Write Target

This block is the target side of a Low Pin Count bus for memory writes only. The host sends one nibble per clock on a 4-bit multiplexed bus, framed by an active-low frame strobe. The block finds the start field and checks that the cycle is a memory write. It then collects a 32-bit address and one data byte from the nibbles that follow.

After the host turnaround, the block drives a ready sync nibble and then its own turnaround nibble, and releases the bus. In the sync clock it pulses a single-cycle write strobe to the internal command logic, with the assembled address and byte.

The bus is modelled as separate input, output and output-enable signals. A pad wrapper joins them into the bidirectional pins. Any cycle type other than a memory write is dropped silently, and the bus stays released.

Top module: `lpc_mem_wr_target`

## Requirements
- R1: After an active-low reset, the block is idle, with `lad_oe` low and `wr_stb` low.
- R2: A cycle starts only on a clock where `lframe_n` is low and `lad_in` is 0000b. While `lframe_n` stays low, the start nibble of the last such clock counts.
- R3: The nibble after the start field, taken with `lframe_n` high, must match 011Xb (0110b or 0111b). Any other value ends the cycle without a strobe.
- R4: The next 8 nibbles form `wr_addr`, most significant nibble first.
- R5: The next 2 nibbles form `wr_data`, low nibble first.
- R6: The block waits 2 host turnaround clocks with `lad_oe` low. In the next clock it drives `lad_out` = 0000b (ready sync) with `lad_oe` high.
- R7: In the clock after sync, the block drives `lad_out` = 1111b with `lad_oe` high. In the clock after that, `lad_oe` is low again.
- R8: `wr_stb` is high for exactly one clock per accepted cycle, in the sync clock, with the assembled `wr_addr` and `wr_data`.
- R9: If `lframe_n` goes low in the middle of a cycle, the cycle is dropped without a strobe. If `lad_in` is 0000b in that clock, it counts as a new start field.
- R10: `lad_oe` is high only in the sync clock and in the target turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Output enable for `lad_out` |
| wr_stb | output | 1 | One-clock write strobe to the command interface |
| wr_addr | output | 32 | Assembled write address |
| wr_data | output | 8 | Assembled write byte |

## Verification
A nibble counter that is off by one moves the sync clock, so `lad_oe` rises a clock early or late. Once the counter is wrong, the captured address or byte is shifted by a nibble when the strobe fires. A wrong sequencer state shows within one or two clocks, as an enable that is held too long or a turnaround nibble that is not 1111b. A missed abort shows as a strobe appearing at the end of a cycle the host had already dropped. A start field that is wrongly accepted or rejected shows in the strobe count.

// File: rtl/lpc_mem_wr_target.sv
module lpc_mem_wr_target #(
  parameter int ADDR_NIBBLES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lframe_n,
  input  logic [3:0]                lad_in,
  output logic [3:0]                lad_out,
  output logic                      lad_oe,
  output logic                      wr_stb,
  output logic [4*ADDR_NIBBLES-1:0] wr_addr,
  output logic [7:0]                wr_data
);

  localparam int AW = 4 * ADDR_NIBBLES;
  localparam int CW = $clog2(ADDR_NIBBLES);

  typedef enum logic [2:0] {
    S_IDLE, S_TYPE, S_ADDR, S_DATA, S_HTAR, S_HFLT, S_SYNC, S_TTAR
  } st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          aborting;

  assign aborting = !lframe_n && st != S_IDLE;

  always_comb begin
    st_nx = st;
    if (!lframe_n) begin
      st_nx = (lad_in == 4'h0) ? S_TYPE : S_IDLE;
    end else begin
      case (st)
        S_IDLE: st_nx = S_IDLE;
        S_TYPE: st_nx = (lad_in[3:1] == 3'b011) ? S_ADDR : S_IDLE;
        S_ADDR: if (cnt == CW'(ADDR_NIBBLES - 1)) st_nx = S_DATA;
        S_DATA: if (cnt[0]) st_nx = S_HTAR;
        S_HTAR: st_nx = S_HFLT;
        S_HFLT: st_nx = S_SYNC;
        S_SYNC: st_nx = S_TTAR;
        S_TTAR: st_nx = S_IDLE;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      if (lframe_n && st == S_ADDR) addr_q <= {addr_q[AW-5:0], lad_in};
      if (lframe_n && st == S_DATA) begin
        if (!cnt[0]) data_q[3:0] <= lad_in;
        else         data_q[7:4] <= lad_in;
      end
    end
  end

  assign lad_oe  = (st == S_SYNC) || (st == S_TTAR);
  assign lad_out = (st == S_SYNC) ? 4'h0 : 4'hF;
  assign wr_stb  = (st == S_SYNC);
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !lad_oe && !wr_stb);

  p_type_checked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && $past(st) == S_TYPE) |-> $past(lad_in[3:1]) == 3'b011);

  p_sync_opens_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> wr_stb && lad_out == 4'h0);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && lframe_n) |=> lad_oe && lad_out == 4'hF && !wr_stb);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_no_strobe_on_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aborting |=> !wr_stb);

  p_oe_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && !wr_stb) |=> !lad_oe);

endmodule

// File: tb/test_lpc_mem_wr_target.sv
module test_lpc_mem_wr_target;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lframe_n = 1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        wr_stb;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  int n_tests = 0;
  int n_fail = 0;
  int stb_cnt = 0;

  lpc_mem_wr_target i_lpc_mem_wr_target (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (wr_stb) stb_cnt++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nib(input logic fr, input logic [3:0] v);
    lframe_n = fr;
    lad_in = v;
    @(posedge clk);
    #1;
  endtask

  task automatic send_head(input logic [3:0] typ, input logic [31:0] a);
    nib(0, 4'h0);
    nib(1, typ);
    for (int i = 7; i >= 0; i--) nib(1, a[4*i +: 4]);
  endtask

  task automatic full_write(input logic [3:0] typ, input logic [31:0] a, input logic [7:0] d);
    send_head(typ, a);
    nib(1, d[3:0]);
    nib(1, d[7:4]);
    nib(1, 4'hF);
    check(lad_oe == 0, "R6 oe low in host turnaround", lad_oe, 0);
    nib(1, 4'hF);
    check(wr_stb == 1, "R8 strobe in sync clock", wr_stb, 1);
    check(lad_oe == 1 && lad_out == 4'h0, "R6 sync 0000 driven", {lad_oe, lad_out}, 5'h10);
    check(wr_addr == a, "R4 address msn first", wr_addr, a);
    check(wr_data == d, "R5 data low nibble first", wr_data, d);
    nib(1, 4'hF);
    check(lad_oe == 1 && lad_out == 4'hF && !wr_stb, "R7 target turnaround 1111",
          {wr_stb, lad_oe, lad_out}, 6'h1F);
    nib(1, 4'hF);
    check(lad_oe == 0, "R7 R10 bus released", lad_oe, 0);
  endtask

  task automatic t_reset();
    #1;
    check(lad_oe == 0 && wr_stb == 0, "R1 reset idle", {lad_oe, wr_stb}, 0);
    repeat (2) @(posedge clk);
    rst_n = 1;
    #1;
    check(lad_oe == 0 && wr_stb == 0, "R1 idle after reset", {lad_oe, wr_stb}, 0);
  endtask

  task automatic t_basic();
    int c0 = stb_cnt;
    full_write(4'h6, 32'hFFBF5555, 8'hAA);
    full_write(4'h7, 32'h12345678, 8'h80);
    nib(1, 4'hF);
    check(stb_cnt == c0 + 2, "R3 R8 one strobe per write, 011X accepted", stb_cnt, c0 + 2);
  endtask

  task automatic t_long_start();
    nib(0, 4'h0);
    nib(0, 4'h0);
    full_write(4'h6, 32'h00002AAA, 8'h55);
  endtask

  task automatic t_reject_type();
    int c0 = stb_cnt;
    send_head(4'h4, 32'hDEADBEEF);
    for (int i = 0; i < 6; i++) begin
      nib(1, 4'hF);
      check(lad_oe == 0, "R10 no drive on non-write", lad_oe, 0);
    end
    check(stb_cnt == c0, "R3 read type ignored", stb_cnt, c0);
  endtask

  task automatic t_bad_start();
    int c0 = stb_cnt;
    nib(0, 4'h2);
    nib(1, 4'h6);
    for (int i = 0; i < 14; i++) nib(1, 4'h0);
    check(stb_cnt == c0 && lad_oe == 0, "R2 nonzero start ignored", stb_cnt, c0);
  endtask

  task automatic t_abort();
    int c0 = stb_cnt;
    nib(0, 4'h0);
    nib(1, 4'h6);
    nib(1, 4'h1);
    nib(1, 4'h2);
    nib(0, 4'h5);
    for (int i = 0; i < 14; i++) nib(1, 4'h0);
    check(stb_cnt == c0 && lad_oe == 0, "R9 abort drops cycle", stb_cnt, c0);
    nib(0, 4'h0);
    nib(1, 4'h6);
    nib(1, 4'h9);
    nib(1, 4'h9);
    full_write(4'h6, 32'hCAFE0123, 8'h3C);
    check(stb_cnt == c0 + 1, "R9 restart after abort gives one strobe", stb_cnt, c0 + 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_long_start();
    t_reject_type();
    t_bad_start();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule